// File: doc/BRIEF.md
# Immediate Saturating Shift-Narrow-Pack Unit

This block takes two 128-bit vectors and shifts every element of both right by a single immediate amount. The first vector is a fresh source. The second is the value currently held in the destination. Each shifted element is clamped to half its width and written into a packed 128-bit result. Four element formats are offered: 16 to 8, 32 to 16, 64 to 32 and 128 to 64 bits. The shift can zero-fill or sign-fill. The clamp can target a signed or an unsigned half-width range.

Narrowed elements from the fresh source fill the lower half of the result. Narrowed elements from the old destination fill the upper half. Every lane is computed from the old destination as presented, so the caller gets the complete replacement value in one transfer. Instruction decode and register write-back stay with the caller. The result is registered, and a valid pulse accompanies it one cycle after the operands.

Top module: `shnarrow_pack`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `new_dst` are cleared to zero at that edge.
- R2: An operand set taken with `in_valid` high at edge k appears on `new_dst` with `out_valid` high after edge k. A cycle with `in_valid` low drives `out_valid` low and leaves `new_dst` unchanged, whatever the other inputs carry.
- R3: Lane i of `src_vec`, narrowed, lands at element i of `new_dst[63:0]`. Lane i of `old_dst`, narrowed, lands at element i of `new_dst[127:64]`. Lane i occupies bits [i*n +: n] of its source for an n-bit format.
- R4: `fmt_sel` selects the format as 0=16→8, 1=32→16, 2=64→32, 3=128→64. The shift amount is `shamt[3:0]`, `shamt[4:0]`, `shamt[5:0]` or `shamt[6:0]` for those formats. Higher `shamt` bits have no effect.
- R5: With `shift_arith`=1 the shift fills with the lane's sign bit, and with 0 it fills with zeros. A shift amount of zero passes the whole lane value to the clamp.
- R6: `sat_uns`=0 and `shift_arith`=0: the shifted lane is read as unsigned and clamped to 2^(h-1)-1 (h = half width), so the result is never negative.
- R7: `sat_uns`=0 and `shift_arith`=1: the shifted lane is read as signed and clamped to the range [-2^(h-1), 2^(h-1)-1].
- R8: `sat_uns`=1 and `shift_arith`=0: the shifted lane is read as unsigned and clamped to 2^h-1.
- R9: `sat_uns`=1 and `shift_arith`=1: a lane with its sign bit set gives 0. Any other lane is clamped to 2^h-1.
- R10: The 128→64 format follows R5 to R9 with shift amounts up to 127, including the bounds 2^63-1, -2^63 and 2^64-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on the inputs are to be processed |
| src_vec | input | 128 | Fresh source vector, feeds the lower result half |
| old_dst | input | 128 | Current destination value, feeds the upper result half |
| shamt | input | 7 | Immediate shift amount, trimmed per format |
| fmt_sel | input | 2 | Element format selector |
| shift_arith | input | 1 | 1 = sign-filling shift, 0 = zero-filling shift |
| sat_uns | input | 1 | 1 = unsigned half-width clamp, 0 = signed clamp |
| out_valid | output | 1 | `new_dst` holds a fresh result |
| new_dst | output | 128 | Packed narrowed result |

## Verification
The two halves of a result are produced by separate lane sets in the same cycle. One half can clamp while the other passes its value through, or the two halves can clamp in opposite directions. Directed vectors provoke this: an overflowing `src_vec` is paired with an in-range or opposite-sign `old_dst`, and each half is compared against an independently computed expectation. A second overlap comes from a back-to-back stream, where a new operand set is accepted in the same cycle the previous result is presented. Idle cycles carrying garbage operands sit between these transfers, and the scoreboard judges each output in arrival order.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
   localparam int unsigned NSP_BASE_W = 16;
   localparam int unsigned NSP_NFMT   = 4;

   typedef enum logic [1:0] {
      NSP_F16  = 2'd0,
      NSP_F32  = 2'd1,
      NSP_F64  = 2'd2,
      NSP_F128 = 2'd3
   } nsp_fmt_e;

   typedef struct packed {
      logic arith;
      logic uns;
   } nsp_mode_t;
endpackage

// File: rtl/nsp_lane.sv
module nsp_lane
   import nsp_pkg::*;
#(
   parameter int unsigned SRC_W = 16,
   localparam int unsigned DST_W = SRC_W / 2,
   localparam int unsigned SH_W  = $clog2(SRC_W)
)(
   input  logic [SRC_W-1:0] src,
   input  logic [SH_W-1:0]  sh,
   input  nsp_mode_t        mode,
   output logic [DST_W-1:0] dst
);
   localparam int unsigned TOP_W = SRC_W - DST_W + 1;

   logic [SRC_W-1:0] shr_a;
   logic [SRC_W-1:0] shr_l;
   logic [SRC_W-1:0] shr;
   logic [TOP_W-1:0] s_top;
   logic             fits_s;
   logic             over_u;
   logic             neg_src;
   logic [DST_W-1:0] s_max;
   logic [DST_W-1:0] s_min;

   assign shr_a   = $signed(src) >>> sh;
   assign shr_l   = src >> sh;
   assign shr     = mode.arith ? shr_a : shr_l;
   assign s_top   = shr[SRC_W-1:DST_W-1];
   assign fits_s  = (s_top == '0) || (mode.arith && (&s_top));
   assign over_u  = |shr[SRC_W-1:DST_W];
   assign neg_src = mode.arith && src[SRC_W-1];
   assign s_max   = {1'b0, {(DST_W-1){1'b1}}};
   assign s_min   = {1'b1, {(DST_W-1){1'b0}}};

   always_comb begin
      if (mode.uns) begin
         if (neg_src)     dst = '0;
         else if (over_u) dst = '1;
         else             dst = shr[DST_W-1:0];
      end else begin
         if (fits_s)                       dst = shr[DST_W-1:0];
         else if (mode.arith && shr[SRC_W-1]) dst = s_min;
         else                              dst = s_max;
      end
   end
endmodule

// File: rtl/nsp_fmt_path.sv
module nsp_fmt_path
   import nsp_pkg::*;
#(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned SRC_W = 16,
   localparam int unsigned LANES = VEC_W / SRC_W,
   localparam int unsigned DST_W = SRC_W / 2,
   localparam int unsigned HALF  = VEC_W / 2,
   localparam int unsigned SH_W  = $clog2(SRC_W)
)(
   input  logic [VEC_W-1:0] src_vec,
   input  logic [VEC_W-1:0] old_dst,
   input  logic [SH_W-1:0]  sh,
   input  nsp_mode_t        mode,
   output logic [VEC_W-1:0] res
);
   if ((VEC_W % SRC_W) != 0 || SRC_W < 4) begin : g_bad_lane
      $error("nsp_fmt_path: lane width must divide vector width");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      nsp_lane #(.SRC_W(SRC_W)) u_lo (
         .src  (src_vec[i*SRC_W +: SRC_W]),
         .sh   (sh),
         .mode (mode),
         .dst  (res[i*DST_W +: DST_W])
      );
      nsp_lane #(.SRC_W(SRC_W)) u_hi (
         .src  (old_dst[i*SRC_W +: SRC_W]),
         .sh   (sh),
         .mode (mode),
         .dst  (res[HALF + i*DST_W +: DST_W])
      );
   end
endmodule

// File: rtl/shnarrow_pack.sv
module shnarrow_pack
   import nsp_pkg::*;
#(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned BASE_W = NSP_BASE_W,
   parameter int unsigned NFMT   = NSP_NFMT,
   localparam int unsigned MAX_W = BASE_W << (NFMT - 1),
   localparam int unsigned IMM_W = $clog2(MAX_W),
   localparam int unsigned FMT_W = (NFMT > 1) ? $clog2(NFMT) : 1,
   localparam int unsigned HALF  = VEC_W / 2
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] src_vec,
   input  logic [VEC_W-1:0] old_dst,
   input  logic [IMM_W-1:0] shamt,
   input  logic [FMT_W-1:0] fmt_sel,
   input  logic             shift_arith,
   input  logic             sat_uns,
   output logic             out_valid,
   output logic [VEC_W-1:0] new_dst
);
   if (NFMT < 1 || (VEC_W % MAX_W) != 0) begin : g_bad_cfg
      $error("shnarrow_pack: widest format must divide the vector width");
   end
   if (BASE_W < 4 || (BASE_W & (BASE_W - 1)) != 0) begin : g_bad_base
      $error("shnarrow_pack: base lane width must be a power of two >= 4");
   end

   nsp_mode_t        mode;
   logic [VEC_W-1:0] path_res [NFMT];
   logic [VEC_W-1:0] sel_res;

   assign mode = '{arith: shift_arith, uns: sat_uns};

   for (genvar f = 0; f < NFMT; f++) begin : g_fmt
      localparam int unsigned SRC_W = BASE_W << f;
      localparam int unsigned SH_W  = $clog2(SRC_W);
      nsp_fmt_path #(.VEC_W(VEC_W), .SRC_W(SRC_W)) u_path (
         .src_vec (src_vec),
         .old_dst (old_dst),
         .sh      (shamt[SH_W-1:0]),
         .mode    (mode),
         .res     (path_res[f])
      );
   end

   always_comb begin
      sel_res = path_res[0];
      for (int f = 1; f < NFMT; f++) begin
         if (fmt_sel == FMT_W'(f)) sel_res = path_res[f];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         new_dst   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) new_dst <= sel_res;
      end
   end

   AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(new_dst))); // R2
   AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && src_vec == '0 && old_dst == '0) |=> (new_dst == '0)); // R3
   AST_UNS_NEG_FLOOR: assert property (@(posedge clk) disable iff (rst)
      (in_valid && sat_uns && shift_arith && fmt_sel == FMT_W'(NFMT-1) && src_vec[MAX_W-1])
      |=> (new_dst[MAX_W/2-1:0] == '0)); // R9
   AST_LOG_SIGNED_NONNEG: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !sat_uns && !shift_arith && fmt_sel == FMT_W'(NFMT-1))
      |=> (!new_dst[MAX_W/2-1] && !new_dst[HALF + MAX_W/2-1])); // R6
endmodule

// File: tb/shnarrow_pack_tb.sv
module shnarrow_pack_tb;
   import nsp_pkg::*;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [127:0] src_vec = '0;
   logic [127:0] old_dst = '0;
   logic [6:0]   shamt = '0;
   logic [1:0]   fmt_sel = '0;
   logic         shift_arith = 1'b0;
   logic         sat_uns = 1'b0;
   logic         out_valid;
   logic [127:0] new_dst;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [127:0] exp_q[$];
   string        tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   shnarrow_pack u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
      .old_dst(old_dst), .shamt(shamt), .fmt_sel(fmt_sel),
      .shift_arith(shift_arith), .sat_uns(sat_uns),
      .out_valid(out_valid), .new_dst(new_dst)
   );

   task automatic check(string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_lane(logic [127:0] x, int n, int s, bit ar, bit un);
      logic signed [129:0] v, hi, lo;
      int h = n / 2;
      for (int b = 0; b < 130; b++) v[b] = (b < n) ? x[b] : (ar ? x[n-1] : 1'b0);
      v  = v >>> s;
      hi = (130'sd1 <<< (un ? h : h - 1)) - 130'sd1;
      lo = un ? 130'sd0 : -(130'sd1 <<< (h - 1));
      if (un && ar && x[n-1]) v = 130'sd0;
      else if (v > hi)        v = hi;
      else if (v < lo)        v = lo;
      return v[63:0];
   endfunction

   function automatic logic [127:0] ref_vec(logic [127:0] a, logic [127:0] d, int imm,
                                            int f, bit ar, bit un);
      logic [127:0] r = '0;
      int n = 16 << f;
      int h = n / 2;
      int s = imm & (n - 1);
      for (int i = 0; i < 128 / n; i++) begin
         logic [127:0] la = '0;
         logic [127:0] ld = '0;
         logic [63:0]  ra, rd;
         for (int b = 0; b < n; b++) begin
            la[b] = a[i*n + b];
            ld[b] = d[i*n + b];
         end
         ra = ref_lane(la, n, s, ar, un);
         rd = ref_lane(ld, n, s, ar, un);
         for (int b = 0; b < h; b++) begin
            r[i*h + b]      = ra[b];
            r[64 + i*h + b] = rd[b];
         end
      end
      return r;
   endfunction

   task automatic send_exp(logic [127:0] a, logic [127:0] d, logic [6:0] imm, nsp_fmt_e f,
                           bit ar, bit un, logic [127:0] exp, string tag);
      @(negedge clk);
      in_valid = 1'b1; src_vec = a; old_dst = d; shamt = imm;
      fmt_sel = f; shift_arith = ar; sat_uns = un;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic send(logic [127:0] a, logic [127:0] d, logic [6:0] imm, nsp_fmt_e f,
                       bit ar, bit un, string tag);
      send_exp(a, d, imm, f, ar, un, ref_vec(a, d, int'(imm), int'(f), ar, un), tag);
   endtask

   task automatic idle(int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         in_valid = 1'b0;
         src_vec = {$urandom(), $urandom(), $urandom(), $urandom()};
         old_dst = {$urandom(), $urandom(), $urandom(), $urandom()};
         shamt = 7'($urandom()); fmt_sel = 2'($urandom());
         shift_arith = 1'($urandom()); sat_uns = 1'($urandom());
      end
   endtask

   // Monitor: pops the scoreboard whenever a result is presented
   initial begin
      logic [127:0] last = '0;
      bit seen = 1'b0;
      forever begin
         @(posedge clk);
         #1;
         if (!rst && !done) begin
            if (out_valid) begin
               if (exp_q.size() == 0) begin
                  checks++; errors++;
                  $display("FAIL R2 unexpected out_valid act=1 exp=0");
               end else begin
                  check(tag_q.pop_front(), new_dst, exp_q.pop_front());
               end
               last = new_dst;
               seen = 1'b1;
            end else if (seen) begin
               check("R2 hold", new_dst, last);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL R2 watchdog act=hung exp=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 out_valid", {127'd0, out_valid}, 128'd0);
      check("R1 new_dst", new_dst, 128'd0);
      @(negedge clk);
      rst = 1'b0;
      idle(2);

      // R3: lane ordering in both halves
      send_exp(128'h0007_0006_0005_0004_0003_0002_0001_0000,
               128'h0017_0016_0015_0014_0013_0012_0011_0010, 7'd0, NSP_F16, 1'b0, 1'b1,
               128'h1716151413121110_0706050403020100, "R3 packing");
      // R5: sign fill versus zero fill
      send_exp({8{16'hFF80}}, '0, 7'd4, NSP_F16, 1'b1, 1'b0,
               {64'h0, 64'hF8F8F8F8F8F8F8F8}, "R5 sign fill");
      send_exp({8{16'hFF80}}, '0, 7'd4, NSP_F16, 1'b0, 1'b0,
               {64'h0, 64'h7F7F7F7F7F7F7F7F}, "R5 zero fill");
      // R4: upper shamt bits ignored
      send_exp({8{16'hFF80}}, '0, 7'h74, NSP_F16, 1'b1, 1'b0,
               {64'h0, 64'hF8F8F8F8F8F8F8F8}, "R4 fmt0 upper bits");
      send_exp({4{32'h0000_0100}}, '0, 7'h61, NSP_F32, 1'b0, 1'b0,
               {64'h0, 64'h0080008000800080}, "R4 fmt1 upper bits");
      // R6: logical signed, zero shift of negative lane clamps at top
      send_exp({8{16'h8000}}, '0, 7'd0, NSP_F16, 1'b0, 1'b0,
               {64'h0, 64'h7F7F7F7F7F7F7F7F}, "R6 top clamp");
      // R7: halves saturating low and passing through in one result
      send_exp({4{32'h8000_0000}}, {4{32'h0000_1234}}, 7'd0, NSP_F32, 1'b1, 1'b0,
               {64'h1234123412341234, 64'h8000800080008000}, "R7 mixed halves");
      // R8: unsigned logical clamp and just-fitting value
      send_exp({2{64'h0000_0001_0000_0000}}, '0, 7'd0, NSP_F64, 1'b0, 1'b1,
               {64'h0, 64'hFFFFFFFFFFFFFFFF}, "R8 clamp");
      send_exp({2{64'h0000_0001_0000_0000}}, '0, 7'd1, NSP_F64, 1'b0, 1'b1,
               {64'h0, 64'h8000000080000000}, "R8 fit");
      idle(2);
      // R9 / R10: widest format bounds
      send_exp(128'h8000_0000_0000_0000_0000_0000_0000_0001,
               128'h0000_0000_0000_0001_0000_0000_0000_0000, 7'd0, NSP_F128, 1'b1, 1'b1,
               {64'hFFFFFFFFFFFFFFFF, 64'h0}, "R9 negative floor");
      send_exp(128'h8000_0000_0000_0000_0000_0000_0000_0000,
               128'h7FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 7'd127, NSP_F128, 1'b1, 1'b0,
               {64'h0, 64'hFFFFFFFFFFFFFFFF}, "R10 shift 127");
      send_exp(128'h0000_0000_0000_0000_8000_0000_0000_0000,
               128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000, 7'd0, NSP_F128, 1'b1, 1'b0,
               {64'h8000000000000000, 64'h7FFFFFFFFFFFFFFF}, "R10 signed bounds");
      idle(3);

      // Random stream: back-to-back and gapped, every mode (R3 R5 R6 R7 R8 R9 R10)
      for (int k = 0; k < 400; k++) begin
         logic [127:0] a = {$urandom(), $urandom(), $urandom(), $urandom()};
         logic [127:0] d = {$urandom(), $urandom(), $urandom(), $urandom()};
         if (k % 5 == 0) a = a >> ($urandom() % 128);
         if (k % 7 == 0) d = ~(d >> ($urandom() % 128));
         send(a, d, 7'($urandom()), nsp_fmt_e'($urandom() % 4), 1'($urandom()),
              1'($urandom()), "R3 random");
         if (k % 9 == 0) idle(1);
      end
      idle(4);
      check("R2 drained", 128'(exp_q.size()), 128'd0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule